// File: doc/BRIEF.md
# Reset-Latched Operating Mode Register

This block samples two mode-select pins on every clock edge while the synchronous reset is held low. It stores the result as the operating-mode fields of an 8-bit control register. Once reset is released the pins are no longer looked at. The mode can then change only through bus writes, and those writes follow asymmetric, mode-dependent permission rules.

The register sits at one bus address. Reads return it combinationally and writes commit on the clock edge. The block also drives a decoded two-bit operating mode, and a select line that marks bus accesses to the boot ROM window while the boot ROM is mapped.

The five low bits are plain read/write storage for priority logic that lies outside this block.

Top module: `opmode_reg`

## Requirements
- R1: While `rst_n` is low, each clock edge loads the mode from the pins, with mode_o = {smod, mda}. Pins b=1, a=0 give single-chip (00). Pins b=1, a=1 give expanded (01). Pins b=0, a=0 give bootstrap (10). Pins b=0, a=1 give special test (11).
- R2: The register bit layout is bit 7 rom_map, bit 6 smod, bit 5 mda, bits 4..0 low storage. After reset, rom_map equals smod and the low bits are 0. The reset read values are 0x00, 0x20, 0xC0 and 0xE0 for the four modes in the order of R1.
- R3: After reset is released, pin changes never alter the register.
- R4: Address 0x103C reads the register; any other address reads 0x00.
- R5: The low five bits take the written data in every mode.
- R6: While smod=1, writes set rom_map, smod and mda freely.
- R7: While smod=0, only the first write after reset that occurs in normal mode changes mda; later writes leave mda unchanged.
- R8: Once smod is 0, no write can set it back to 1.
- R9: While smod=0, writes leave rom_map unchanged.
- R10: `rom_sel_o` is 1 exactly when rom_map=1, smod=1 and the address lies in 0xBF00..0xBFFF.
- R11: A write takes effect only when `wr_en_i` is 1 and the address is 0x103C. Any other access neither changes the register nor uses up the one-time mda write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the mode pins are sampled while it is low |
| mode_a_i | input | 1 | Mode-select pin A |
| mode_b_i | input | 1 | Mode-select pin B |
| addr_i | input | 16 | Bus address |
| wdata_i | input | 8 | Bus write data |
| wr_en_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Register read data, 0 when the address does not match |
| mode_o | output | 2 | Operating mode {smod, mda} |
| rom_sel_o | output | 1 | Boot ROM window select |

## Verification
The bench builds the block with its default parameters: a 16-bit address, the register at 0x103C and the ROM window at 0xBF00..0xBFFF. This lets it probe both window edges and the addresses just outside them. The defaults also let it walk every pin combination and move from each special mode into a normal one by writing. Because the one-time mda write is consumed only by a normal-mode write, that transition case can be reached and checked.

// File: rtl/opmode_pkg.sv
package opmode_pkg;

    localparam int LOW_W = 5;

    typedef enum logic [1:0] {
        MODE_SINGLE   = 2'b00,
        MODE_EXPANDED = 2'b01,
        MODE_BOOT     = 2'b10,
        MODE_TEST     = 2'b11
    } opmode_e;

    // bit 7 rom_map, bit 6 smod, bit 5 mda, bits 4..0 low storage
    typedef struct packed {
        logic             rom_map;
        logic             smod;
        logic             mda;
        logic [LOW_W-1:0] low;
    } mode_reg_t;

    typedef struct packed {
        mode_reg_t regv;
        logic      mda_lock;
    } mode_state_t;

endpackage

// File: rtl/opmode_pin_decode.sv
module opmode_pin_decode
    import opmode_pkg::*;
(
    input  logic      pin_a,
    input  logic      pin_b,
    output mode_reg_t reset_img
);
    always_comb begin
        reset_img         = '0;
        reset_img.mda     = pin_a;
        reset_img.smod    = ~pin_b;
        reset_img.rom_map = ~pin_b;
    end
endmodule

// File: rtl/opmode_wr_policy.sv
module opmode_wr_policy
    import opmode_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  mode_reg_t         cur,
    input  logic              lock,
    input  logic [DATA_W-1:0] wdata,
    output mode_reg_t         nxt,
    output logic              nxt_lock
);
    localparam int ROM_BIT  = DATA_W - 1;
    localparam int SMOD_BIT = DATA_W - 2;
    localparam int MDA_BIT  = DATA_W - 3;

    logic special;

    always_comb begin
        special      = cur.smod;
        nxt.low      = wdata[LOW_W-1:0];
        nxt.rom_map  = special ? wdata[ROM_BIT] : cur.rom_map;
        nxt.smod     = special & wdata[SMOD_BIT];
        nxt.mda      = (special || !lock) ? wdata[MDA_BIT] : cur.mda;
        nxt_lock     = lock | ~special;
    end
endmodule

// File: rtl/opmode_rom_window.sv
module opmode_rom_window #(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'hBF00,
    parameter logic [ADDR_W-1:0] LAST   = 16'hBFFF
) (
    input  logic              enable,
    input  logic [ADDR_W-1:0] addr,
    output logic              sel
);
    always_comb begin
        sel = enable && (addr >= BASE) && (addr <= LAST);
    end
endmodule

// File: rtl/opmode_reg.sv
module opmode_reg
    import opmode_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'h103C,
    parameter logic [ADDR_W-1:0] ROM_BASE = 16'hBF00,
    parameter logic [ADDR_W-1:0] ROM_LAST = 16'hBFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_a_i,
    input  logic              mode_b_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              wr_en_i,
    output logic [7:0]        rdata_o,
    output logic [1:0]        mode_o,
    output logic              rom_sel_o
);
    localparam int DATA_W = $bits(mode_reg_t);

    mode_state_t st_d, st_q;
    mode_reg_t   reset_img, pol_nxt;
    logic        pol_lock, wr_hit, reg_hit;

    opmode_pin_decode u_pins (
        .pin_a     (mode_a_i),
        .pin_b     (mode_b_i),
        .reset_img (reset_img)
    );

    opmode_wr_policy #(.DATA_W(DATA_W)) u_policy (
        .cur      (st_q.regv),
        .lock     (st_q.mda_lock),
        .wdata    (wdata_i),
        .nxt      (pol_nxt),
        .nxt_lock (pol_lock)
    );

    opmode_rom_window #(.ADDR_W(ADDR_W), .BASE(ROM_BASE), .LAST(ROM_LAST)) u_rom (
        .enable (st_q.regv.rom_map & st_q.regv.smod),
        .addr   (addr_i),
        .sel    (rom_sel_o)
    );

    always_comb begin
        reg_hit = (addr_i == REG_ADDR);
        wr_hit  = reg_hit && wr_en_i;
        st_d    = st_q;
        if (!rst_n) begin
            st_d.regv     = reset_img;
            st_d.mda_lock = 1'b0;
        end else if (wr_hit) begin
            st_d.regv     = pol_nxt;
            st_d.mda_lock = pol_lock;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rdata_o = reg_hit ? st_q.regv : '0;
    assign mode_o  = {st_q.regv.smod, st_q.regv.mda};
endmodule

// File: rtl/opmode_reg_chk.sv
module opmode_reg_chk
    import opmode_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'h103C,
    parameter logic [ADDR_W-1:0] ROM_BASE = 16'hBF00,
    parameter logic [ADDR_W-1:0] ROM_LAST = 16'hBFFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_a_i,
    input logic              mode_b_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic [1:0]        mode_o,
    input logic              rom_sel_o,
    input mode_reg_t         reg_q,
    input logic              lock_q
);
    logic wr_hit;
    assign wr_hit = wr_en_i && (addr_i == REG_ADDR);

    // R1
    pin_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && !$past(rst_n)) |-> (mode_o == {~$past(mode_b_i), $past(mode_a_i)}));

    // R3
    no_pin_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(reg_q));

    // R8
    smod_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_o[1] |=> !mode_o[1]);

    // R9
    rom_map_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_q.smod && wr_hit) |=> $stable(reg_q.rom_map));

    // R7
    mda_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_q.smod && lock_q && wr_hit) |=> $stable(reg_q.mda));

    // R10
    rom_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel_o |-> (mode_o[1] && addr_i >= ROM_BASE && addr_i <= ROM_LAST));
endmodule

bind opmode_reg opmode_reg_chk #(
    .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .ROM_BASE(ROM_BASE), .ROM_LAST(ROM_LAST)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_a_i  (mode_a_i),
    .mode_b_i  (mode_b_i),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .mode_o    (mode_o),
    .rom_sel_o (rom_sel_o),
    .reg_q     (st_q.regv),
    .lock_q    (st_q.mda_lock)
);

// File: tb/opmode_reg_tb.sv
module opmode_reg_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] RA = 16'h103C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_a = 1'b0, mode_b = 1'b1;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  rdata;
    logic [1:0]  mode;
    logic        rom_sel;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opmode_reg u_dut (
        .clk(clk), .rst_n(rst_n), .mode_a_i(mode_a), .mode_b_i(mode_b),
        .addr_i(addr), .wdata_i(wdata), .wr_en_i(wr_en),
        .rdata_o(rdata), .mode_o(mode), .rom_sel_o(rom_sel)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic a, input logic b);
        @(negedge clk);
        rst_n = 1'b0; mode_a = a; mode_b = b; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d, input logic en);
        addr = a; wdata = d; wr_en = en;
        @(negedge clk);
        wr_en = 1'b0; addr = RA;
        #1;
    endtask

    task automatic read_chk(input string req, input logic [7:0] exp);
        addr = RA; #1;
        check(req, rdata, exp);
    endtask

    task automatic t_reset_modes();
        do_reset(1'b0, 1'b1); read_chk("R1 R2 single", 8'h00); check("R1 mode single", {6'd0, mode}, 8'h00);
        do_reset(1'b1, 1'b1); read_chk("R1 R2 expanded", 8'h20); check("R1 mode expanded", {6'd0, mode}, 8'h01);
        do_reset(1'b0, 1'b0); read_chk("R1 R2 boot", 8'hC0); check("R1 mode boot", {6'd0, mode}, 8'h02);
        do_reset(1'b1, 1'b0); read_chk("R1 R2 test", 8'hE0); check("R1 mode test", {6'd0, mode}, 8'h03);
    endtask

    task automatic t_pins_ignored();
        do_reset(1'b0, 1'b1);
        mode_a = 1'b1; mode_b = 1'b0;
        repeat (4) @(negedge clk);
        read_chk("R3 pins after release", 8'h00);
        addr = 16'h103D; #1; check("R4 other address", rdata, 8'h00);
    endtask

    task automatic t_normal_writes();
        do_reset(1'b0, 1'b1);
        bus_wr(RA, 8'hFF, 1'b1); read_chk("R5 R7 R9 first normal write", 8'h3F);
        bus_wr(RA, 8'h00, 1'b1); read_chk("R7 mda locked", 8'h20);
        bus_wr(RA, 8'h40, 1'b1); read_chk("R8 smod not settable", 8'h20);
        do_reset(1'b1, 1'b1);
        bus_wr(RA, 8'h00, 1'b1); read_chk("R7 expanded first write", 8'h00);
        bus_wr(RA, 8'h20, 1'b1); read_chk("R7 expanded locked", 8'h00);
    endtask

    task automatic t_decode_writes();
        do_reset(1'b0, 1'b1);
        bus_wr(16'h103D, 8'hFF, 1'b1); read_chk("R11 wrong address", 8'h00);
        bus_wr(RA, 8'hFF, 1'b0);       read_chk("R11 strobe low", 8'h00);
        bus_wr(RA, 8'h20, 1'b1);       read_chk("R11 lock not consumed", 8'h20);
    endtask

    task automatic t_special_writes();
        do_reset(1'b1, 1'b0);
        bus_wr(RA, 8'h00, 1'b1); read_chk("R6 leave special", 8'h00);
        bus_wr(RA, 8'hE0, 1'b1); read_chk("R7 R8 R9 first normal after special", 8'h20);
        bus_wr(RA, 8'h00, 1'b1); read_chk("R7 locked after special", 8'h20);
        do_reset(1'b0, 1'b0);
        bus_wr(RA, 8'h67, 1'b1); read_chk("R6 free write 1", 8'h67);
        bus_wr(RA, 8'h9F, 1'b1); read_chk("R6 free write 2", 8'h9F);
        bus_wr(RA, 8'hC0, 1'b1); read_chk("R9 R8 normal after boot", 8'h80);
        addr = 16'hBF10; #1; check("R10 smod clear", {7'd0, rom_sel}, 8'h00);
    endtask

    task automatic t_rom_window();
        do_reset(1'b0, 1'b0);
        addr = 16'hBF00; #1; check("R10 low edge", {7'd0, rom_sel}, 8'h01);
        addr = 16'hBFFF; #1; check("R10 high edge", {7'd0, rom_sel}, 8'h01);
        addr = 16'hBEFF; #1; check("R10 below", {7'd0, rom_sel}, 8'h00);
        addr = 16'hC000; #1; check("R10 above", {7'd0, rom_sel}, 8'h00);
        @(negedge clk);
        bus_wr(RA, 8'h40, 1'b1);
        addr = 16'hBF80; #1; check("R10 map off", {7'd0, rom_sel}, 8'h00);
    endtask

    initial begin
        fork
            begin
                t_reset_modes();
                t_pins_ignored();
                t_normal_writes();
                t_decode_writes();
                t_special_writes();
                t_rom_window();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule